// File: doc/BRIEF.md
# Segmentable SIMD Adder With Lane Carries

This block is a registered 48-bit adder/subtracter whose carry chain can be split at run time. A two-bit mode input selects one full-width lane, two 24-bit lanes or four 12-bit lanes. In the split modes each lane is an independent adder: no carry crosses a lane boundary. The block adds or subtracts the plain operands only. No product or other pre-computed value enters it.

The datapath is four identical 12-bit field adders. A small planning stage decides, per field, whether the carry into it comes from the field below or starts a new lane. A carry-out vector with one bit per 12-bit field reports the carry leaving each lane at that lane's top field. During subtraction a set carry-out bit means no borrow. The sum and the carry vector are captured in an output register that has a clock enable and a synchronous reset.

Top module: `simd_lane_adder`

## Requirements
- R1: With mode code 0 the block is one 48-bit adder: the carry ripples across all fields, `carry_o[3]` is the carry out of bit 47 and `carry_o[2:0]` read 0.
- R2: With mode code 1 the operands form two 24-bit lanes (bits 23:0 and 47:24): no carry passes from bit 23 into bit 24, `carry_o[1]` and `carry_o[3]` are the lane carries, and `carry_o[0]` and `carry_o[2]` read 0.
- R3: With mode code 2 (and code 3, which acts the same) there are four 12-bit lanes: no carry passes into bits 12, 24 or 36, and `carry_o[i]` is the carry out of field i (bits 12*i+11 down to 12*i).
- R4: With `sub_i` = 1 each lane above the lowest computes A + ~B + 1 over its own width, and a lane carry-out of 1 means the lane did not borrow.
- R5: `carry_in_i` enters only the lowest lane, as a carry when adding and as a borrow when subtracting (lowest lane = A - B - carry_in_i). Higher lanes never see it.
- R6: Results appear on `sum_o` and `carry_o` one clock after the edge that samples the inputs with `en` = 1.
- R7: While `en` = 0 and `rst` = 0, `sum_o` and `carry_o` keep their values whatever the other inputs do.
- R8: `rst` = 1 at a clock edge clears `sum_o` and `carry_o` to 0. Reset takes priority over `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the output register |
| mode_i | input | 2 | Lane split: 0 one 48-bit, 1 two 24-bit, 2 or 3 four 12-bit |
| sub_i | input | 1 | 1 = subtract op_b_i from op_a_i in every lane |
| carry_in_i | input | 1 | Carry (add) or borrow (subtract) into the lowest lane |
| op_a_i | input | 48 | First operand |
| op_b_i | input | 48 | Second operand |
| sum_o | output | 48 | Registered lane results |
| carry_o | output | 4 | Registered carry-out per 12-bit field |

## Verification
Two things can happen in the same cycle and must be told apart: a lane producing a carry at its top, and the lane above it being all ones. The all-ones lane would wrap if that carry leaked across the boundary. The bench sets up this case on purpose, with fields of all ones over a carrying lower field, in every mode and in both add and subtract. The same collision arises when a carry-in or borrow-in lands at the lowest lane while its neighbour sits at a boundary value. A behavioural per-lane model, built from integer arithmetic over each lane's width, predicts the sum and every carry bit. The outputs are compared with that model on every clock, so a carry leaking into the wrong lane shows up as a wrong sum and a wrong carry bit in the cycle it happens.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    localparam int PKG_FIELD_W    = 12;
    localparam int PKG_NUM_FIELDS = 4;

    // Lane split selection as seen on the mode input.
    typedef enum logic [1:0] {
        LM_WIDE     = 2'd0,
        LM_HALF     = 2'd1,
        LM_QUAD     = 2'd2,
        LM_QUAD_ALT = 2'd3
    } lane_mode_e;

    // Number of 12-bit fields that make up one lane in the given mode.
    function automatic int lane_span(lane_mode_e m, int nf);
        case (m)
            LM_WIDE: return nf;
            LM_HALF: return nf / 2;
            default: return 1;
        endcase
    endfunction

    // Carry injected at the bottom of a lane: the lowest lane takes the
    // external carry (inverted into a borrow when subtracting), the others
    // take the +1 of two's complement subtraction.
    function automatic logic lane_seed(bit lowest, logic sub, logic cin);
        return lowest ? (cin ^ sub) : sub;
    endfunction

endpackage

// File: rtl/simd_field_add.sv
module simd_field_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] total;

    always_comb begin
        total  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = total[W-1:0];
        cout_o = total[W];
    end
endmodule

// File: rtl/simd_lane_plan.sv
module simd_lane_plan
    import simd_add_pkg::*;
#(
    parameter int NUM_FIELDS = 4
) (
    input  lane_mode_e            mode_i,
    input  logic                  sub_i,
    input  logic                  carry_in_i,
    output logic [NUM_FIELDS-1:0] start_o,  // field begins a lane
    output logic [NUM_FIELDS-1:0] seed_o,   // carry injected at lane start
    output logic [NUM_FIELDS-1:0] top_o     // field ends a lane
);
    int span;

    always_comb begin
        span = lane_span(mode_i, NUM_FIELDS);
        for (int i = 0; i < NUM_FIELDS; i++) begin
            start_o[i] = ((i % span) == 0);
            top_o[i]   = (((i + 1) % span) == 0);
            seed_o[i]  = lane_seed(i == 0, sub_i, carry_in_i);
        end
    end
endmodule

// File: rtl/simd_result_reg.sv
module simd_result_reg #(
    parameter int DATA_W     = 48,
    parameter int NUM_FIELDS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [DATA_W-1:0]     sum_d,
    input  logic [NUM_FIELDS-1:0] carry_d,
    output logic [DATA_W-1:0]     sum_q,
    output logic [NUM_FIELDS-1:0] carry_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (en) begin
            sum_q   <= sum_d;
            carry_q <= carry_d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum_q == '0 && carry_q == '0)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sum_q) && $stable(carry_q))); // R7
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_add_pkg::*;
#(
    parameter int FIELD_W    = PKG_FIELD_W,
    parameter int NUM_FIELDS = PKG_NUM_FIELDS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [1:0]                    mode_i,
    input  logic                          sub_i,
    input  logic                          carry_in_i,
    input  logic [FIELD_W*NUM_FIELDS-1:0] op_a_i,
    input  logic [FIELD_W*NUM_FIELDS-1:0] op_b_i,
    output logic [FIELD_W*NUM_FIELDS-1:0] sum_o,
    output logic [NUM_FIELDS-1:0]         carry_o
);
    localparam int DATA_W = FIELD_W * NUM_FIELDS;
    localparam int HALF_SPAN = NUM_FIELDS / 2;

    lane_mode_e            mode_e;
    logic [NUM_FIELDS-1:0] start_m;
    logic [NUM_FIELDS-1:0] seed_m;
    logic [NUM_FIELDS-1:0] top_m;
    logic [DATA_W-1:0]     sum_d;
    logic [NUM_FIELDS-1:0] carry_d;

    assign mode_e = lane_mode_e'(mode_i);

    simd_lane_plan #(.NUM_FIELDS(NUM_FIELDS)) u_plan (
        .mode_i     (mode_e),
        .sub_i      (sub_i),
        .carry_in_i (carry_in_i),
        .start_o    (start_m),
        .seed_o     (seed_m),
        .top_o      (top_m)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        logic               cin_f;
        logic               cout_f;
        logic               below_f;
        logic [FIELD_W-1:0] b_f;
        logic [FIELD_W-1:0] s_f;

        if (i == 0) begin : g_base
            assign below_f = 1'b0;
        end else begin : g_link
            assign below_f = g_fld[i-1].cout_f;
        end

        assign cin_f = start_m[i] ? seed_m[i] : below_f;
        assign b_f   = op_b_i[i*FIELD_W +: FIELD_W] ^ {FIELD_W{sub_i}};

        simd_field_add #(.W(FIELD_W)) u_add (
            .a_i    (op_a_i[i*FIELD_W +: FIELD_W]),
            .b_i    (b_f),
            .cin_i  (cin_f),
            .sum_o  (s_f),
            .cout_o (cout_f)
        );

        assign sum_d[i*FIELD_W +: FIELD_W] = s_f;
        assign carry_d[i] = cout_f & top_m[i];

        if (i != NUM_FIELDS - 1) begin : g_wide_chk
            AST_WIDE_INNER_QUIET: assert property (@(posedge clk) disable iff (rst)
                (en && mode_e == LM_WIDE) |=> !carry_o[i]); // R1
        end

        if (((i + 1) % HALF_SPAN) != 0) begin : g_half_chk
            AST_HALF_INNER_QUIET: assert property (@(posedge clk) disable iff (rst)
                (en && mode_e == LM_HALF) |=> !carry_o[i]); // R2
        end
    end

    simd_result_reg #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .sum_d   (sum_d),
        .carry_d (carry_d),
        .sum_q   (sum_o),
        .carry_q (carry_o)
    );

    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        en |=> (sum_o == $past(sum_d))); // R6
endmodule

// File: tb/simd_lane_adder_test.sv
module simd_lane_adder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [1:0]  mode_i;
    logic        sub_i;
    logic        carry_in_i;
    logic [47:0] op_a_i;
    logic [47:0] op_b_i;
    logic [47:0] sum_o;
    logic [3:0]  carry_o;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    checking = 0;
    string tag = "R8";

    logic [47:0] exp_sum = '0;
    logic [3:0]  exp_carry = '0;

    always #4 clk = ~clk; // 125 MHz

    simd_lane_adder uut (
        .clk(clk), .rst(rst), .en(en), .mode_i(mode_i), .sub_i(sub_i),
        .carry_in_i(carry_in_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .sum_o(sum_o), .carry_o(carry_o)
    );

    // Behavioural per-lane arithmetic.
    function automatic void model(input logic [1:0] m, input logic s, input logic c,
                                  input logic [47:0] a, input logic [47:0] b,
                                  output logic [47:0] so, output logic [3:0] co);
        int w;
        int nl;
        logic [63:0] mask;
        w = (m == 2'd0) ? 48 : (m == 2'd1) ? 24 : 12;
        nl = 48 / w;
        mask = (64'd1 << w) - 64'd1;
        so = '0;
        co = '0;
        for (int k = 0; k < nl; k++) begin
            logic [63:0] av, bv, tot;
            logic cs;
            av = ({16'd0, a} >> (k * w)) & mask;
            bv = ({16'd0, (s ? ~b : b)} >> (k * w)) & mask;
            cs = (k == 0) ? (s ? !c : c) : s;
            tot = av + bv + {63'd0, cs};
            so = so | 48'((tot & mask) << (k * w));
            co[((k + 1) * w) / 12 - 1] = tot[w];
        end
    endfunction

    always @(posedge clk) begin
        logic [47:0] ns;
        logic [3:0]  nc;
        if (rst) begin
            exp_sum   = '0;
            exp_carry = '0;
        end else if (en) begin
            model(mode_i, sub_i, carry_in_i, op_a_i, op_b_i, ns, nc);
            exp_sum   = ns;
            exp_carry = nc;
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            total++;
            if (sum_o !== exp_sum || carry_o !== exp_carry) begin
                bad++;
                $display("FAIL %s: sum=%h carry=%b expected sum=%h carry=%b",
                         tag, sum_o, carry_o, exp_sum, exp_carry);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(input logic [1:0] m, input logic s, input logic c,
                         input logic [47:0] a, input logic [47:0] b);
        @(negedge clk);
        mode_i = m; sub_i = s; carry_in_i = c; op_a_i = a; op_b_i = b;
    endtask

    initial begin
        rst = 1'b1; en = 1'b1; mode_i = 2'd0; sub_i = 1'b0; carry_in_i = 1'b0;
        op_a_i = 48'hFFFF_FFFF_FFFF; op_b_i = 48'h1;
        repeat (3) @(negedge clk);
        checking = 1;      // R8: reset state observed from here on
        rst = 1'b0;

        // R1: full-width carry from bit 11 through bit 47
        tag = "R1";
        drive(2'd0, 0, 0, 48'hFFFF_FFFF_FFFF, 48'h1);
        drive(2'd0, 0, 0, 48'h0000_0000_0FFF, 48'h1);
        drive(2'd0, 0, 1, 48'h7FFF_FFFF_FFFF, 48'h0);
        drive(2'd0, 0, 0, 48'h8000_0000_0000, 48'h8000_0000_0000);

        // R2: carry out of lower 24-bit lane into an all-ones upper lane
        tag = "R2";
        drive(2'd1, 0, 0, 48'hFFFFFF_FFFFFF, 48'h000000_000001);
        drive(2'd1, 0, 0, 48'h000000_FFFFFF, 48'h000000_000001);
        drive(2'd1, 0, 1, 48'hFFFFFF_000FFF, 48'h000001_000000);

        // R3: four lanes, every boundary provoked, both codes 2 and 3
        tag = "R3";
        drive(2'd2, 0, 0, 48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001);
        drive(2'd2, 0, 0, 48'hFFF_FFF_FFF_FFF, 48'h000_000_000_001);
        drive(2'd3, 0, 0, 48'hFFF_FFF_FFF_FFF, 48'h000_000_000_001);
        drive(2'd3, 0, 0, 48'h800_FFF_000_FFF, 48'h800_001_000_001);

        // R4: subtraction, borrow and no-borrow per lane
        tag = "R4";
        drive(2'd2, 1, 0, 48'h005_003_000_010, 48'h003_005_001_010);
        drive(2'd1, 1, 0, 48'h000000_000005, 48'h000001_000007);
        drive(2'd0, 1, 0, 48'h0, 48'h1);
        drive(2'd0, 1, 0, 48'h1234_5678_9ABC, 48'h1234_5678_9ABC);

        // R5: carry/borrow only into the lowest lane
        tag = "R5";
        drive(2'd2, 0, 1, 48'hFFF_FFF_FFF_FFF, 48'h0);
        drive(2'd1, 0, 1, 48'h0, 48'h0);
        drive(2'd2, 1, 1, 48'h000_000_000_000, 48'h000_000_000_000);
        drive(2'd1, 1, 1, 48'h000010_000010, 48'h000010_000010);

        // R6: back-to-back changes, each result one cycle later
        tag = "R6";
        for (int i = 0; i < 8; i++)
            drive(2'(i % 4), 1'(i % 2), 1'(i / 4), 48'(64'h1111_1111_1111 * i), 48'hFFF_FFF_FFF_FFF);

        // R7: enable low, inputs wander, outputs hold
        tag = "R7";
        drive(2'd2, 0, 0, 48'h123_456_789_ABC, 48'h111_111_111_111);
        @(negedge clk); en = 1'b0;
        drive(2'd0, 1, 1, 48'hFFFF_FFFF_FFFF, 48'h1);
        drive(2'd1, 0, 1, 48'h0F0F_0F0F_0F0F, 48'hF0F0_F0F0_F0F0);
        drive(2'd3, 1, 0, 48'h0, 48'h5);
        @(negedge clk); en = 1'b1;

        // R8: reset while enabled takes priority
        tag = "R8";
        drive(2'd0, 0, 0, 48'hAAAA_AAAA_AAAA, 48'h5555_5555_5555);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;

        // Mixed random traffic across all modes
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            m = 2'($urandom % 4);
            tag = (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : "R3";
            en = ($urandom % 8) != 0;
            drive(m, 1'($urandom % 2), 1'($urandom % 2),
                  48'({$urandom, $urandom}), 48'({$urandom, $urandom}));
        end
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checking = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule